// File: doc/BRIEF.md
# Dual-Port Synchronous Word Memory with Per-Port Read Latency

This block is a true dual-port word memory. Two independent access ports, A and B, share one storage array. Each port samples its address, write data, enables, byte-lane selects and read/write line on the rising clock edge. A read on a port returns data with one of two latencies, chosen by a static per-port mode input:

- **Flow-through mode:** the word appears in the cycle that follows the edge that sampled its address.
- **Pipelined mode:** the word appears one clock later.

The block does not drive a tri-state bus. Each port presents a data word plus one valid flag per byte lane. A lane whose flag is low carries zeros. A per-port active-low drive enable turns both flags off at once, without waiting for a clock.

Each port runs a four-state enable tracker that stands in for the pipeline on the chip-select path:

- **IDLE:** not selected at the last two edges.
- **WAKE:** selected at the last edge only.
- **LIVE:** selected at both of the last two edges.
- **DRAIN:** selected at the edge before last only.

The transitions depend only on whether the port is selected at the current edge:

| From  | Selected → | Not selected → |
|-------|------------|----------------|
| IDLE  | WAKE       | IDLE           |
| WAKE  | LIVE       | DRAIN          |
| LIVE  | LIVE       | DRAIN          |
| DRAIN | WAKE       | IDLE           |

In flow-through mode the outputs may be active in WAKE or LIVE. In pipelined mode they may be active in LIVE or DRAIN. Both ports share one clock. When both ports write the same word at the same edge, port A wins.

Top module: `dpr_sync`

## Requirements
- R1: A port counts as selected at an edge only when its `sel_n` is 0 and its `sel_hi` is 1. In flow-through mode, a port not selected at an edge has `rvalid` = 2'b00 in the following cycle.
- R2: A write is an edge at which the port is selected and `rd_wr` = 0. It stores bits 15..8 when `hi_n` = 0 and bits 7..0 when `lo_n` = 0. Lanes whose select is 1 keep their old contents.
- R3: Flag `rvalid[1]` covers bits 15..8 and `rvalid[0]` covers bits 7..0. A lane's flag can be 1 only after a read edge (`rd_wr` = 1) at which that lane's select was 0. Data bits of a lane whose flag is 0 read as zero.
- R4: While `drv_n` = 1, both `rvalid` bits are 0 at once, with no clock edge needed. Clearing `drv_n` restores them at once.
- R5: In flow-through mode (`pipe_mode` = 0), a read sampled at edge N shows the word at its address, including any write made at edge N, during the cycle after edge N.
- R6: In pipelined mode (`pipe_mode` = 1), the same word appears during the cycle after edge N+1. The read flag follows that one-cycle delay.
- R7: The lane selects pass through exactly one register in both modes. In pipelined mode, the lane flags after edge N+1 follow the lane selects sampled at edge N+1.
- R8: Port selection passes through one register in flow-through mode and two in pipelined mode. In pipelined mode, deselection at edge N turns the outputs off after edge N+1. Reselection needs two selected edges before data is shown again.
- R9: After a port writes a word at edge N, a read of that address by the other port sampled at edge N or later returns the new data.
- R10: When both ports write the same address at the same edge, the stored value of each lane written by port A is port A's data.
- R11: Reset clears every pipeline register and the enable tracker. Both ports show `rvalid` = 2'b00 and `rdata` = 0 until a valid read is issued.
- R12: When a port's address and controls stay unchanged across clocks and nothing writes that address, its output data stays constant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both ports, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| a_pipe_mode | input | 1 | Port A latency mode: 0 flow-through, 1 pipelined (static) |
| a_sel_n | input | 1 | Port A active-low enable |
| a_sel_hi | input | 1 | Port A active-high enable |
| a_rd_wr | input | 1 | Port A direction: 1 read, 0 write |
| a_hi_n | input | 1 | Port A active-low select of bits 15..8 |
| a_lo_n | input | 1 | Port A active-low select of bits 7..0 |
| a_drv_n | input | 1 | Port A asynchronous active-low output drive enable |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A read data, zero in lanes not valid |
| a_rvalid | output | 2 | Port A lane valid flags {upper, lower} |
| b_pipe_mode | input | 1 | Port B latency mode: 0 flow-through, 1 pipelined (static) |
| b_sel_n | input | 1 | Port B active-low enable |
| b_sel_hi | input | 1 | Port B active-high enable |
| b_rd_wr | input | 1 | Port B direction: 1 read, 0 write |
| b_hi_n | input | 1 | Port B active-low select of bits 15..8 |
| b_lo_n | input | 1 | Port B active-low select of bits 7..0 |
| b_drv_n | input | 1 | Port B asynchronous active-low output drive enable |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B read data, zero in lanes not valid |
| b_rvalid | output | 2 | Port B lane valid flags {upper, lower} |

## Verification
Random traffic is confined to sixteen addresses, so collisions and read-after-write between the ports happen often. It is run under all four pairings of the two mode inputs, which separates an error in the one-stage paths from one in the two-stage paths. Directed sequences cover four things:

- Each half of the two-input enable and each lane mask on its own.
- A drive-enable toggle in mid-cycle, which shows the gating is truly combinational.
- A lane-select change between a pipelined read and its data cycle, which separates single-registered lane selects from data-aligned ones.
- A one-edge deselect inside a pipelined burst, which checks the two-edge reactivation.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

    // Enable tracker: bit 1 = selected at the edge before last, bit 0 = selected at the last edge
    typedef enum logic [1:0] {
        PS_IDLE  = 2'b00,
        PS_WAKE  = 2'b01,
        PS_DRAIN = 2'b10,
        PS_LIVE  = 2'b11
    } port_state_e;

    localparam int LANES = 2;

endpackage

// File: rtl/dpr_array.sv
module dpr_array
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] wa_addr,
    input  logic [DATA_W-1:0] wa_data,
    input  logic [LANES-1:0]  wa_lane,
    input  logic [ADDR_W-1:0] wb_addr,
    input  logic [DATA_W-1:0] wb_data,
    input  logic [LANES-1:0]  wb_lane,
    input  logic [ADDR_W-1:0] ra_addr,
    input  logic [ADDR_W-1:0] rb_addr,
    output logic [DATA_W-1:0] ra_word,
    output logic [DATA_W-1:0] rb_word
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int LANE_W = DATA_W / LANES;

    logic [DATA_W-1:0] mem [DEPTH];

    // Port B is applied first so that port A overrides it on a shared word
    always_ff @(posedge clk) begin
        for (int l = 0; l < LANES; l++) begin
            if (wb_lane[l]) mem[wb_addr][l*LANE_W +: LANE_W] <= wb_data[l*LANE_W +: LANE_W];
            if (wa_lane[l]) mem[wa_addr][l*LANE_W +: LANE_W] <= wa_data[l*LANE_W +: LANE_W];
        end
    end

    assign ra_word = mem[ra_addr];
    assign rb_word = mem[rb_addr];

    // R10
    a_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wa_lane == 2'b11 && wb_lane == 2'b11 && wa_addr == wb_addr)
        |=> (mem[$past(wa_addr)] == $past(wa_data)));

    // R2
    lane_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wa_lane == 2'b10 && wb_lane == 2'b00)
        |=> (mem[$past(wa_addr)][LANE_W-1:0] == $past(mem[wa_addr][LANE_W-1:0])));

endmodule

// File: rtl/dpr_port.sv
module dpr_port
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pipe_mode,
    input  logic              sel_n,
    input  logic              sel_hi,
    input  logic              rd_wr,
    input  logic              hi_n,
    input  logic              lo_n,
    input  logic              drv_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] mem_word,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [LANES-1:0]  wr_lane,
    output logic [DATA_W-1:0] rdata,
    output logic [LANES-1:0]  rvalid
);
    localparam int LANE_W = DATA_W / LANES;

    logic              sel_now;
    logic [LANES-1:0]  lane_now;
    port_state_e       state, state_nxt;
    logic [ADDR_W-1:0] addr_q;
    logic [LANES-1:0]  lane_q;
    logic              rd_q1, rd_q2;
    logic [DATA_W-1:0] data_q;
    logic              lane_on;
    logic [DATA_W-1:0] word;

    assign sel_now  = !sel_n && sel_hi;
    assign lane_now = ~{hi_n, lo_n};
    assign wr_lane  = {LANES{sel_now && !rd_wr}} & lane_now;
    assign rd_addr  = addr_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= PS_IDLE;
        else        state <= state_nxt;
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            PS_IDLE:  state_nxt = sel_now ? PS_WAKE : PS_IDLE;
            PS_WAKE:  state_nxt = sel_now ? PS_LIVE : PS_DRAIN;
            PS_LIVE:  state_nxt = sel_now ? PS_LIVE : PS_DRAIN;
            PS_DRAIN: state_nxt = sel_now ? PS_WAKE : PS_IDLE;
        endcase
    end

    // Registered address, lanes, direction and pipeline data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            lane_q <= '0;
            rd_q1  <= 1'b0;
            rd_q2  <= 1'b0;
            data_q <= '0;
        end else begin
            addr_q <= addr;
            lane_q <= lane_now;
            rd_q1  <= rd_wr;
            rd_q2  <= rd_q1;
            data_q <= mem_word;
        end
    end

    // Output decode: enable stage and data source depend on the latency mode
    always_comb begin
        logic en_flow, en_pipe;
        en_flow = (state == PS_WAKE) || (state == PS_LIVE);
        en_pipe = (state == PS_LIVE) || (state == PS_DRAIN);
        if (pipe_mode) begin
            lane_on = !drv_n && en_pipe && rd_q2;
            word    = data_q;
        end else begin
            lane_on = !drv_n && en_flow && rd_q1;
            word    = mem_word;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign rvalid[g]                   = lane_on && lane_q[g];
        assign rdata[g*LANE_W +: LANE_W]   = rvalid[g] ? word[g*LANE_W +: LANE_W] : '0;
    end

    // R1
    desel_flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_mode && !sel_now) |=> (rvalid == '0));

    // R8
    desel_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_mode && !sel_now) |=> ##1 (rvalid == '0));

    // R3
    upper_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid[1] |-> !$past(hi_n));

    // R3
    write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_mode && sel_now && !rd_wr) |=> (rvalid == '0));

    // R4
    drive_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drv_n |-> (rvalid == '0));

endmodule

// File: rtl/dpr_sync.sv
module dpr_sync
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_pipe_mode,
    input  logic              a_sel_n,
    input  logic              a_sel_hi,
    input  logic              a_rd_wr,
    input  logic              a_hi_n,
    input  logic              a_lo_n,
    input  logic              a_drv_n,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    output logic [1:0]        a_rvalid,
    input  logic              b_pipe_mode,
    input  logic              b_sel_n,
    input  logic              b_sel_hi,
    input  logic              b_rd_wr,
    input  logic              b_hi_n,
    input  logic              b_lo_n,
    input  logic              b_drv_n,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata,
    output logic [1:0]        b_rvalid
);
    logic [ADDR_W-1:0] a_rd_addr, b_rd_addr;
    logic [LANES-1:0]  a_wr_lane, b_wr_lane;
    logic [DATA_W-1:0] a_word, b_word;

    dpr_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port_a (
        .clk(clk), .rst_n(rst_n), .pipe_mode(a_pipe_mode),
        .sel_n(a_sel_n), .sel_hi(a_sel_hi), .rd_wr(a_rd_wr),
        .hi_n(a_hi_n), .lo_n(a_lo_n), .drv_n(a_drv_n),
        .addr(a_addr), .mem_word(a_word), .rd_addr(a_rd_addr),
        .wr_lane(a_wr_lane), .rdata(a_rdata), .rvalid(a_rvalid)
    );

    dpr_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port_b (
        .clk(clk), .rst_n(rst_n), .pipe_mode(b_pipe_mode),
        .sel_n(b_sel_n), .sel_hi(b_sel_hi), .rd_wr(b_rd_wr),
        .hi_n(b_hi_n), .lo_n(b_lo_n), .drv_n(b_drv_n),
        .addr(b_addr), .mem_word(b_word), .rd_addr(b_rd_addr),
        .wr_lane(b_wr_lane), .rdata(b_rdata), .rvalid(b_rvalid)
    );

    dpr_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk(clk), .rst_n(rst_n),
        .wa_addr(a_addr), .wa_data(a_wdata), .wa_lane(a_wr_lane),
        .wb_addr(b_addr), .wb_data(b_wdata), .wb_lane(b_wr_lane),
        .ra_addr(a_rd_addr), .rb_addr(b_rd_addr),
        .ra_word(a_word), .rb_word(b_word)
    );

endmodule

// File: tb/dpr_sync_test.sv
module dpr_sync_test;
    localparam int ADDR_W = 10;
    localparam int DATA_W = 16;
    localparam time HALF  = 4ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic              pm [2];
    logic              sn [2];
    logic              sh [2];
    logic              rw [2];
    logic              hn [2];
    logic              ln [2];
    logic              dn [2];
    logic [ADDR_W-1:0] ad [2];
    logic [DATA_W-1:0] wd [2];
    logic [DATA_W-1:0] a_rdata, b_rdata;
    logic [1:0]        a_rvalid, b_rvalid;

    int vectors = 0;
    int errors  = 0;

    // Reference model state
    logic [DATA_W-1:0] shmem [16];
    logic       m_s1 [2];
    logic       m_s2 [2];
    logic       m_r1 [2];
    logic       m_r2 [2];
    logic [1:0] m_bs [2];
    logic [DATA_W-1:0] m_w1 [2];
    logic [DATA_W-1:0] m_pw [2];

    always #HALF clk = ~clk;

    dpr_sync #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .a_pipe_mode(pm[0]), .a_sel_n(sn[0]), .a_sel_hi(sh[0]), .a_rd_wr(rw[0]),
        .a_hi_n(hn[0]), .a_lo_n(ln[0]), .a_drv_n(dn[0]), .a_addr(ad[0]),
        .a_wdata(wd[0]), .a_rdata(a_rdata), .a_rvalid(a_rvalid),
        .b_pipe_mode(pm[1]), .b_sel_n(sn[1]), .b_sel_hi(sh[1]), .b_rd_wr(rw[1]),
        .b_hi_n(hn[1]), .b_lo_n(ln[1]), .b_drv_n(dn[1]), .b_addr(ad[1]),
        .b_wdata(wd[1]), .b_rdata(b_rdata), .b_rvalid(b_rvalid)
    );

    function automatic logic [1:0] exp_valid(int p);
        logic en, rd;
        en = pm[p] ? m_s2[p] : m_s1[p];
        rd = pm[p] ? m_r2[p] : m_r1[p];
        return {2{!dn[p] && en && rd}} & m_bs[p];
    endfunction

    function automatic logic [DATA_W-1:0] exp_data(int p);
        logic [1:0] v;
        logic [DATA_W-1:0] w;
        v = exp_valid(p);
        w = pm[p] ? m_pw[p] : m_w1[p];
        return w & {{8{v[1]}}, {8{v[0]}}};
    endfunction

    // Model update at a rising edge, using the inputs held across it
    task automatic model_edge();
        logic sel [2];
        if (!rst_n) begin
            for (int p = 0; p < 2; p++) begin
                m_s1[p] = 0; m_s2[p] = 0; m_r1[p] = 0; m_r2[p] = 0;
                m_bs[p] = 0; m_pw[p] = 0; m_w1[p] = shmem[ad[p][3:0]];
            end
            return;
        end
        for (int p = 0; p < 2; p++) sel[p] = !sn[p] && sh[p];
        for (int p = 1; p >= 0; p--) begin
            if (sel[p] && !rw[p]) begin
                if (!hn[p]) shmem[ad[p][3:0]][15:8] = wd[p][15:8];
                if (!ln[p]) shmem[ad[p][3:0]][7:0]  = wd[p][7:0];
            end
        end
        for (int p = 0; p < 2; p++) begin
            m_pw[p] = m_w1[p];
            m_s2[p] = m_s1[p]; m_s1[p] = sel[p];
            m_r2[p] = m_r1[p]; m_r1[p] = rw[p];
            m_bs[p] = ~{hn[p], ln[p]};
            m_w1[p] = shmem[ad[p][3:0]];
        end
    endtask

    task automatic compare(string tag);
        logic [DATA_W-1:0] ad_act;
        logic [1:0] av_act;
        for (int p = 0; p < 2; p++) begin
            ad_act = (p == 0) ? a_rdata : b_rdata;
            av_act = (p == 0) ? a_rvalid : b_rvalid;
            vectors++;
            if (av_act !== exp_valid(p) || ad_act !== exp_data(p)) begin
                errors++;
                $display("FAIL %s port %0d: actual valid=%b data=%h expected valid=%b data=%h",
                         tag, p, av_act, ad_act, exp_valid(p), exp_data(p));
            end
        end
    endtask

    task automatic tick(string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic drive(int p, logic en, logic rd, logic hi, logic lo,
                         logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
        sn[p] = !en; sh[p] = 1'b1; rw[p] = rd;
        hn[p] = !hi; ln[p] = !lo; dn[p] = 1'b0;
        ad[p] = a; wd[p] = d;
    endtask

    task automatic idle(int p);
        drive(p, 1'b0, 1'b1, 1'b1, 1'b1, '0, '0);
    endtask

    task automatic do_reset(logic pa, logic pb);
        pm[0] = pa; pm[1] = pb;
        idle(0); idle(1);
        rst_n = 1'b0;
        tick("R11");
        tick("R11");
        rst_n = 1'b1;
        tick("R11");
    endtask

    task automatic random_run(int n);
        string tg;
        for (int i = 0; i < n; i++) begin
            for (int p = 0; p < 2; p++) begin
                int k;
                k = $urandom % 10;
                drive(p, k < 8, ($urandom % 10) < 6, $urandom % 2 == 0, $urandom % 2 == 0,
                      ADDR_W'($urandom % 16), DATA_W'($urandom));
                if (k >= 8) begin
                    sn[p] = ($urandom % 2 == 0);
                    sh[p] = sn[p] ? ($urandom % 2 == 0) : 1'b0;
                end
                dn[p] = (($urandom % 10) == 0);
            end
            tg = (pm[0] || pm[1]) ? "R6" : "R5";
            tick(tg);
        end
    endtask

    initial begin
        #(HALF * 2 * 200000);
        errors++;
        $display("FAIL R5 watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20250611));
        for (int i = 0; i < 16; i++) shmem[i] = '0;
        @(negedge clk);
        do_reset(1'b0, 1'b0);

        // R2: preload every test address through port A, both lanes
        for (int i = 0; i < 16; i++) begin
            drive(0, 1'b1, 1'b0, 1'b1, 1'b1, ADDR_W'(i), DATA_W'(16'hA000 + i * 16'h0111));
            tick("R2");
        end

        // R1: each half of the enable pair on its own
        drive(0, 1'b1, 1'b1, 1'b1, 1'b1, 10'd3, '0); sn[0] = 1'b1;
        tick("R1");
        drive(0, 1'b1, 1'b1, 1'b1, 1'b1, 10'd3, '0); sh[0] = 1'b0;
        tick("R1");
        drive(0, 1'b1, 1'b1, 1'b1, 1'b1, 10'd3, '0);
        tick("R1");

        // R2: upper-lane write, then full read
        drive(0, 1'b1, 1'b0, 1'b1, 1'b0, 10'd5, 16'h5A5A);
        tick("R2");
        drive(0, 1'b1, 1'b1, 1'b1, 1'b1, 10'd5, '0);
        tick("R2");

        // R3: lower lane only
        drive(0, 1'b1, 1'b1, 1'b0, 1'b1, 10'd5, '0);
        tick("R3");

        // R4: drive enable toggled mid-cycle
        drive(0, 1'b1, 1'b1, 1'b1, 1'b1, 10'd6, '0);
        tick("R4");
        dn[0] = 1'b1; #1; compare("R4");
        dn[0] = 1'b0; #1; compare("R4");

        // R12: hold a read steady
        drive(0, 1'b1, 1'b1, 1'b1, 1'b1, 10'd7, '0);
        for (int i = 0; i < 3; i++) tick("R12");

        // R9: A writes, B reads the same word at the same and next edge
        drive(0, 1'b1, 1'b0, 1'b1, 1'b1, 10'd9, 16'hC3C3);
        drive(1, 1'b1, 1'b1, 1'b1, 1'b1, 10'd9, '0);
        tick("R9");
        idle(0);
        tick("R9");

        // R10: both write the same word, then both read it
        drive(0, 1'b1, 1'b0, 1'b1, 1'b1, 10'd10, 16'h1111);
        drive(1, 1'b1, 1'b0, 1'b1, 1'b1, 10'd10, 16'h2222);
        tick("R10");
        drive(0, 1'b1, 1'b1, 1'b1, 1'b1, 10'd10, '0);
        drive(1, 1'b1, 1'b1, 1'b1, 1'b1, 10'd10, '0);
        tick("R10");
        tick("R10");

        // Pipelined directed cases
        do_reset(1'b1, 1'b1);
        // R6: back-to-back reads
        drive(0, 1'b1, 1'b1, 1'b1, 1'b1, 10'd3, '0);
        tick("R6");
        drive(0, 1'b1, 1'b1, 1'b1, 1'b1, 10'd4, '0);
        tick("R6");
        tick("R6");
        // R7: lane select changes between the read and its data cycle
        drive(0, 1'b1, 1'b1, 1'b1, 1'b1, 10'd3, '0);
        tick("R7");
        drive(0, 1'b1, 1'b1, 1'b1, 1'b0, 10'd3, '0);
        tick("R7");
        tick("R7");
        // R8: one-edge deselect inside a burst
        drive(0, 1'b1, 1'b1, 1'b1, 1'b1, 10'd8, '0);
        tick("R8");
        tick("R8");
        sn[0] = 1'b1;
        tick("R8");
        sn[0] = 1'b0;
        tick("R8");
        tick("R8");
        tick("R8");

        for (int m = 0; m < 4; m++) begin
            do_reset(m[0], m[1]);
            random_run(600);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule